// File: doc/BRIEF.md
# UART transmitter with transmit-end interrupt

This block sends bytes over an asynchronous serial line. Software writes a byte into a one-byte holding register. It then hands the byte to the transmitter by clearing the holding-empty flag in the status register. When the serial shifter is free, it takes the byte, which sets the empty flag again. The shifter then sends a frame of one start bit, the data bits least significant first, and one stop bit. It moves one bit position on each bit-rate tick.

When the stop bit ends, the next step depends on the holding register. If it holds a valid byte, the next frame starts with no idle time. If it does not, the line stays high and a transmit-end flag is set. The transmit-end flag, ANDed with an enable bit, drives the interrupt output.

A status flag can be cleared only after software has read it as 1. To cancel the interrupt, software either reads the status and then clears the empty flag, which also clears the transmit-end flag, or clears the enable bit.

Top module: `uart_tx_end`

## Requirements
- R1: After reset, `txd_o` is 1 and `tx_end_irq_o` is 0. The status register (address 1) reads 3: bit 0 is the empty flag and bit 1 is the transmit-end flag, and both are 1. The control register (address 2) reads 0.
- R2: A frame is one start bit of 0, then DATA_W data bits least significant first, then one stop bit of 1. Each bit after the start bit is presented after one more `baud_tick_i` pulse.
- R3: Writing 0 to status bit 0 clears the empty flag only if a status read has returned the empty flag as 1 since the flag was last set. Otherwise the write is ignored. Writing 1 to any status bit has no effect.
- R4: Clearing the empty flag also clears the transmit-end flag, which drops the interrupt.
- R5: When the transmitter is idle and the empty flag is 0, the byte at address 0 moves to the shifter on the next clock. The start bit then drives the line and the empty flag reads 1.
- R6: If the empty flag is 0 when a stop-bit tick arrives, the next frame's start bit appears in the cycle after that tick, and the transmit-end flag stays 0.
- R7: If the empty flag is 1 when a stop-bit tick arrives, the transmit-end flag sets and `txd_o` stays 1 while the transmitter is idle.
- R8: `tx_end_irq_o` equals the transmit-end flag ANDed with control bit 0, which resets to 0. Clearing control bit 0 drops the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; a status read can arm the clear |
| reg_addr_i | input | 2 | 0 data, 1 status, 2 control |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| txd_o | output | 1 | Serial line, high when idle |
| tx_end_irq_o | output | 1 | Transmit-end interrupt request |

## Verification
The assertions assume that each register access is a single-cycle strobe and that `baud_tick_i` is at most one cycle wide. They also assume that a status clear landing on the same edge as a stop-bit tick resolves to a load on the next clock.

The stimulus keeps every register access between ticks, so a stop-bit tick never coincides with a status write. Each new byte is queued during the start bit of the frame before it, with a read of the status register before each clear. This drives all 256 byte values back to back, then lets the last frame end with the register empty.

// File: rtl/uart_te_pkg.sv
package uart_te_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
  localparam int unsigned STAT_EMPTY_BIT  = 0;
  localparam int unsigned STAT_END_BIT    = 1;
  localparam int unsigned CTRL_IRQ_EN_BIT = 0;
endpackage

// File: rtl/uart_te_shifter.sv
module uart_te_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               last_bit;

  assign last_bit = busy_q && tick_i && (cnt_q == LAST_POS);
  // take a byte when idle, or at the end of the stop bit for a gapless frame
  assign load_o   = valid_i && (!busy_q || last_bit);
  assign done_o   = last_bit && !valid_i;
  assign busy_o   = busy_q;
  assign txd_o    = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_o) begin
      sh_q   <= {1'b1, data_i, 1'b0};
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (done_o) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/uart_te_regs.sv
module uart_te_regs
  import uart_te_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  load_i,
  input  logic                  done_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [DATA_W-1:0]     hold_o,
  output logic                  valid_o,
  output logic                  empty_o,
  output logic                  end_o,
  output logic                  irq_en_o,
  output logic                  armed_o
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q, end_q, armed_q, irq_en_q;
  logic              stat_wr, stat_rd, clr_req;
  reg_addr_e         addr;

  assign addr    = reg_addr_e'(addr_i);
  assign stat_wr = wr_i && (addr == ADDR_STAT);
  assign stat_rd = rd_i && (addr == ADDR_STAT);
  // clear only honoured after the flag was observed as 1
  assign clr_req = stat_wr && !wdata_i[STAT_EMPTY_BIT] && armed_q && empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (load_i) begin
      empty_q <= 1'b1;
      end_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (clr_req) begin
      empty_q <= 1'b0;
      end_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (done_i) end_q <= 1'b1;
      if (stat_rd && empty_q) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      irq_en_q <= 1'b0;
    end else if (wr_i) begin
      if (addr == ADDR_DATA) hold_q <= wdata_i;
      if (addr == ADDR_CTRL) irq_en_q <= wdata_i[CTRL_IRQ_EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      ADDR_DATA: rdata_o = hold_q;
      ADDR_STAT: begin
        rdata_o[STAT_EMPTY_BIT] = empty_q;
        rdata_o[STAT_END_BIT]   = end_q;
      end
      ADDR_CTRL: rdata_o[CTRL_IRQ_EN_BIT] = irq_en_q;
      default:   rdata_o = '0;
    endcase
  end

  assign hold_o   = hold_q;
  assign valid_o  = !empty_q;
  assign empty_o  = empty_q;
  assign end_o    = end_q;
  assign irq_en_o = irq_en_q;
  assign armed_o  = armed_q;
endmodule

// File: rtl/uart_tx_end.sv
module uart_tx_end
  import uart_te_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  baud_tick_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  txd_o,
  output logic                  tx_end_irq_o
);
  logic [DATA_W-1:0] hold;
  logic valid, empty, tend, irq_en, armed, load, done, busy;

  uart_te_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .load_i   (load),
    .done_i   (done),
    .rdata_o  (reg_rdata_o),
    .hold_o   (hold),
    .valid_o  (valid),
    .empty_o  (empty),
    .end_o    (tend),
    .irq_en_o (irq_en),
    .armed_o  (armed)
  );

  uart_te_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .valid_i (valid),
    .data_i  (hold),
    .load_o  (load),
    .done_o  (done),
    .busy_o  (busy),
    .txd_o   (txd_o)
  );

  assign tx_end_irq_o = tend && irq_en;
endmodule

// File: rtl/uart_tx_end_chk.sv
module uart_tx_end_chk
  import uart_te_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_wr_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic                  wbit0,
  input logic                  empty,
  input logic                  tend,
  input logic                  armed,
  input logic                  load,
  input logic                  done,
  input logic                  busy,
  input logic                  txd_o,
  input logic                  tx_end_irq_o
);
  // R3
  clear_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty) |-> $past(reg_wr_i && reg_addr_i == ADDR_STAT && !wbit0 && armed));
  // R4
  end_clear_with_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tend) |-> ($fell(empty) || $rose(empty)));
  // R5
  load_starts_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (!txd_o && empty && busy));
  // R7
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);
  // R7
  done_sets_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (tend && txd_o));
  // R8
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_end_irq_o) |-> $past(done || (reg_wr_i && reg_addr_i == ADDR_CTRL)));
endmodule

bind uart_tx_end uart_tx_end_chk i_uart_tx_end_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .wbit0        (reg_wdata_i[0]),
  .empty        (empty),
  .tend         (tend),
  .armed        (armed),
  .load         (load),
  .done         (done),
  .busy         (busy),
  .txd_o        (txd_o),
  .tx_end_irq_o (tx_end_irq_o)
);

// File: tb/test_uart_tx_end.sv
module test_uart_tx_end;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni, baud_tick_i, reg_wr_i, reg_rd_i;
  logic [1:0]        reg_addr_i;
  logic [DATA_W-1:0] reg_wdata_i, reg_rdata_o;
  logic              txd_o, tx_end_irq_o;
  int vectors = 0;
  int miscompares = 0;

  uart_tx_end #(.DATA_W(DATA_W)) i_uart_tx_end (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic tick);
    baud_tick_i = tick;
    @(posedge clk_i);
    #1;
    baud_tick_i = 1'b0;
    reg_wr_i    = 1'b0;
    reg_rd_i    = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc(1'b0);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DATA_W-1:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    cyc(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] s;
    rst_ni = 1'b0; baud_tick_i = 1'b0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
    reg_addr_i = '0; reg_wdata_i = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    cyc(1'b0);
    chk("R1", "txd", txd_o, 1);
    chk("R1", "irq", tx_end_irq_o, 0);

    // clear without a prior status read must be ignored
    reg_write(2'd0, 8'h5A);
    reg_write(2'd1, 8'h00);
    cyc(1'b0); cyc(1'b0);
    chk("R3", "txd after unarmed clear", txd_o, 1);
    reg_read(2'd1, s);
    chk("R1", "status", s, 3);
    chk("R3", "status after unarmed clear", s, 3);
    reg_read(2'd2, s);
    chk("R1", "ctrl", s, 0);

    reg_write(2'd2, 8'h01);
    chk("R8", "irq enabled", tx_end_irq_o, 1);
    reg_write(2'd2, 8'h00);
    chk("R8", "irq disabled", tx_end_irq_o, 0);
    reg_write(2'd2, 8'h01);

    reg_write(2'd1, 8'hFF);
    reg_read(2'd1, s);
    chk("R3", "status after writing ones", s, 3);

    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'h00);
    chk("R4", "irq after clear", tx_end_irq_o, 0);
    chk("R5", "txd before load", txd_o, 1);
    cyc(1'b0);
    chk("R5", "start bit", txd_o, 0);
    reg_read(2'd1, s);
    chk("R5", "status after load", s, 1);

    for (int b = 0; b < 256; b++) begin
      if (b < 255) begin
        reg_write(2'd0, DATA_W'(b + 1));
        reg_read(2'd1, s);
        chk("R5", "status on load", s, 1);
        reg_write(2'd1, 8'h00);
      end
      chk("R2", "start", txd_o, 0);
      for (int i = 0; i < DATA_W; i++) begin
        cyc(1'b1);
        chk("R2", "data bit", txd_o, (b >> i) & 1);
      end
      cyc(1'b1);
      chk("R2", "stop", txd_o, 1);
      cyc(1'b1);
      if (b < 255) begin
        chk("R6", "next start", txd_o, 0);
        chk("R6", "irq", tx_end_irq_o, 0);
      end else begin
        chk("R7", "idle line", txd_o, 1);
        chk("R8", "irq at end", tx_end_irq_o, 1);
      end
    end

    for (int k = 0; k < 12; k++) begin
      cyc(k[0]);
      chk("R7", "idle hold", txd_o, 1);
    end
    reg_read(2'd1, s);
    chk("R7", "status at end", s, 3);
    reg_write(2'd2, 8'h00);
    chk("R8", "irq cancelled by enable", tx_end_irq_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule